// File: doc/BRIEF.md
# Snooping Write-Back Coherence Controller

This block keeps one small direct-mapped write-back cache coherent with its peers on a shared, atomic snooping bus. Every line carries one of three states: Invalid (no data), Shared (readable, clean) or Exclusive (sole copy, writable, dirty). The processor side presents a read or write and holds it until the controller reports completion. A hit completes in the same cycle. A miss is answered after the controller has won the bus and run the transaction.

The bus side raises a request, waits for the grant, and then drives one single-cycle transaction: a read miss, a write miss (which also invalidates other copies) or the write-back of a dirty victim. At the same time the controller watches every transaction that other caches place on the bus. When it owns a dirty copy of the snooped block, it drives that block onto the snoop data lines and raises an intervene signal, so that memory does not answer. If a snoop changes the line that a waiting request depends on, the controller drops its bus request and evaluates the processor request again from the start.

Addresses are word addresses. The low log2(LINES) bits select the line and the remaining bits form the tag. The default is 16 lines of one 32-bit word each.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After synchronous active-low reset every line is Invalid, `bus_req_o`, `cpu_done_o` and `cpu_stall_o` are low, and the first access to any address misses and runs a bus transaction.
- R2: A processor write to a line held Shared is a miss. It issues a write miss (`bus_cmd_o` = 2) before the line becomes Exclusive, and it does not complete in the request cycle.
- R3: A read miss issues command 1 and fills the line as Shared with the bus read data. A write miss issues command 2 and fills the line as Exclusive with the processor data. `cpu_done_o` rises in the cycle after the granted transaction.
- R4: A read hit in Shared or Exclusive, and a write hit in Exclusive, complete in the cycle the request is presented, with no bus request.
- R5: A snooped write miss (command 2) whose address matches a held line invalidates that line. If the line was Exclusive, the controller first intervenes with its dirty data, so that memory is updated and the requester gets the block.
- R6: A snooped read miss (command 1) that matches an Exclusive line makes the controller intervene and supply the data, and the line drops to Shared. A later processor write to that line needs the bus again.
- R7: `snp_data_o` is all zeros in every cycle in which `snp_intervene_o` is low.
- R8: A miss whose line is Exclusive with a different tag first writes back the victim (command 3, the address formed from the victim tag and the index, the victim data), and only then issues its own miss.
- R9: While the controller waits for the grant, the line does not change unless a snoop does so. A snoop that changes the indexed line during the wait makes the controller withdraw its request and start again, recomputing which transactions the request still needs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid_i | input | 1 | Processor request present; held until done |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address {tag, index} |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_done_o | output | 1 | Request completes at this clock edge |
| cpu_miss_o | output | 1 | Request found missing this cycle |
| cpu_stall_o | output | 1 | Request present but not completing |
| cpu_rdata_o | output | DATA_W | Read data, valid while done |
| bus_req_o | output | 1 | Bus arbitration request |
| bus_gnt_i | input | 1 | Bus grant |
| bus_valid_o | output | 1 | Own transaction on the bus this cycle |
| bus_cmd_o | output | 2 | 1 read miss, 2 write miss, 3 write-back |
| bus_addr_o | output | ADDR_W | Transaction address |
| bus_wdata_o | output | DATA_W | Write-back data |
| bus_rdata_i | input | DATA_W | Fill data from memory or an intervening cache |
| snp_valid_i | input | 1 | Another cache's transaction is on the bus |
| snp_cmd_i | input | 2 | Snooped command, same encoding |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_intervene_o | output | 1 | This cache supplies the block; memory must not answer |
| snp_data_o | output | DATA_W | Supplied block, zero otherwise |

## Verification
Two controllers share a bench-modelled bus and memory. They are driven through cold misses, repeated hits, a write to a clean shared line, ownership passing back and forth on one address, and a conflicting eviction. Cold misses and hits are told apart by completion latency and by the count of transactions per command. Upgrade, intervention and invalidation are told apart by which cache intervenes and by the data the other cache and memory end up with. The restart case holds one controller off the bus while the peer reads its dirty victim: a correct design drops the now-needless write-back and issues only the read. A design that fails to restart issues a write-back, and a design that ignores the snoop returns the wrong data to the peer.

// File: rtl/coh_pkg.sv
// Package: shared encodings for the snooping coherence controller.
// Assumes two-bit command and state fields throughout the block.
package coh_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE = 2'd0,
        BC_RD   = 2'd1,
        BC_RDX  = 2'd2,
        BC_WB   = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_WB   = 2'd1,
        FS_MISS = 2'd2,
        FS_RESP = 2'd3
    } fsm_st_e;

endpackage

// File: rtl/coh_line_store.sv
// Module: line store for the direct-mapped cache (state, tag, data per line).
// Two combinational read ports: one for the processor index, one for the
// snooped index. Two write ports: a full-line write from the request FSM
// and a state-only write from the snoop unit. Assumes the two never target
// the same line in one cycle; when they do, the snoop write takes priority.
module coh_line_store
    import coh_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rda_idx_i,
    output line_st_e          rda_st_o,
    output logic [TAG_W-1:0]  rda_tag_o,
    output logic [DATA_W-1:0] rda_data_o,
    input  logic [IDX_W-1:0]  rdb_idx_i,
    output line_st_e          rdb_st_o,
    output logic [TAG_W-1:0]  rdb_tag_o,
    output logic [DATA_W-1:0] rdb_data_o,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  line_st_e          wr_st_i,
    input  logic [TAG_W-1:0]  wr_tag_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              sw_en_i,
    input  logic [IDX_W-1:0]  sw_idx_i,
    input  line_st_e          sw_st_i
);

    line_st_e          st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Line state: reset to Invalid, snoop update over FSM update.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g] <= LS_INV;
            end else if (sw_en_i && sw_idx_i == IDX_W'(g)) begin
                st_q[g] <= sw_st_i;
            end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
                st_q[g] <= wr_st_i;
            end
        end

        // Tag and data: written only by the request FSM.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q[g]  <= '0;
                data_q[g] <= '0;
            end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
                tag_q[g]  <= wr_tag_i;
                data_q[g] <= wr_data_i;
            end
        end
    end

    // Read ports: plain indexed lookups.
    always_comb begin
        rda_st_o   = st_q[rda_idx_i];
        rda_tag_o  = tag_q[rda_idx_i];
        rda_data_o = data_q[rda_idx_i];
        rdb_st_o   = st_q[rdb_idx_i];
        rdb_tag_o  = tag_q[rdb_idx_i];
        rdb_data_o = data_q[rdb_idx_i];
    end

    AST_NO_PORT_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_en_i && wr_en_i && sw_idx_i == wr_idx_i)); // R5

    AST_SNOOP_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        sw_en_i |=> st_q[$past(sw_idx_i)] == $past(sw_st_i)); // R5

endmodule

// File: rtl/coh_snoop_unit.sv
// Module: snoop responder. Looks at another cache's bus transaction and the
// line at the snooped index, and decides on intervention and the line's new
// state. Purely combinational; assumes write-backs from peers need no action.
module coh_snoop_unit
    import coh_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              snp_valid_i,
    input  bus_cmd_e          snp_cmd_i,
    input  logic [TAG_W-1:0]  snp_tag_i,
    input  line_st_e          line_st_i,
    input  logic [TAG_W-1:0]  line_tag_i,
    input  logic [DATA_W-1:0] line_data_i,
    output logic              upd_en_o,
    output line_st_e          upd_st_o,
    output logic              intervene_o,
    output logic [DATA_W-1:0] data_o
);

    logic match;

    // Match: a valid peer transaction to a block this cache holds.
    always_comb begin
        match = snp_valid_i && (line_st_i != LS_INV) && (line_tag_i == snp_tag_i);
    end

    // Response: read miss downgrades an owner, write miss kills any copy.
    always_comb begin
        upd_en_o    = 1'b0;
        upd_st_o    = line_st_i;
        intervene_o = 1'b0;
        if (match) begin
            unique case (snp_cmd_i)
                BC_RD: begin
                    if (line_st_i == LS_EXC) begin
                        upd_en_o    = 1'b1;
                        upd_st_o    = LS_SHR;
                        intervene_o = 1'b1;
                    end
                end
                BC_RDX: begin
                    upd_en_o    = 1'b1;
                    upd_st_o    = LS_INV;
                    intervene_o = (line_st_i == LS_EXC);
                end
                default: ;
            endcase
        end
        data_o = intervene_o ? line_data_i : '0;
    end

endmodule

// File: rtl/coh_req_fsm.sv
// Module: processor-request sequencer. Serves hits at once. On a miss it
// arbitrates, optionally writes back a dirty victim, then issues the miss and
// fills the line. Assumes the processor holds its request until done, that the
// bus is atomic, and that grant and a peer snoop never share a cycle.
module coh_req_fsm
    import coh_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    localparam int ADDR_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid_i,
    input  logic              cpu_we_i,
    input  logic [TAG_W-1:0]  cpu_tag_i,
    input  logic [IDX_W-1:0]  cpu_idx_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic              cpu_done_o,
    output logic              cpu_miss_o,
    output logic [DATA_W-1:0] cpu_rdata_o,
    input  line_st_e          line_st_i,
    input  logic [TAG_W-1:0]  line_tag_i,
    input  logic [DATA_W-1:0] line_data_i,
    input  logic              snp_chg_i,
    input  logic [IDX_W-1:0]  snp_idx_i,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    output logic              bus_valid_o,
    output bus_cmd_e          bus_cmd_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic              wr_en_o,
    output line_st_e          wr_st_o,
    output logic [TAG_W-1:0]  wr_tag_o,
    output logic [DATA_W-1:0] wr_data_o
);

    fsm_st_e st_q, st_d;
    logic    pend_hit, tag_eq, hit_ok, waiting;

    // Lookup: does the held line satisfy the request, and is it being snooped.
    always_comb begin
        tag_eq   = (line_tag_i == cpu_tag_i) && (line_st_i != LS_INV);
        hit_ok   = tag_eq && (!cpu_we_i || line_st_i == LS_EXC);
        pend_hit = snp_chg_i && (snp_idx_i == cpu_idx_i);
        waiting  = (st_q == FS_WB) || (st_q == FS_MISS);
    end

    // Sequencer: next state, bus drive and line update.
    always_comb begin
        st_d        = st_q;
        cpu_done_o  = 1'b0;
        cpu_miss_o  = 1'b0;
        bus_req_o   = 1'b0;
        bus_valid_o = 1'b0;
        bus_cmd_o   = BC_NONE;
        bus_addr_o  = '0;
        bus_wdata_o = '0;
        wr_en_o     = 1'b0;
        wr_st_o     = line_st_i;
        wr_tag_o    = line_tag_i;
        wr_data_o   = line_data_i;
        unique case (st_q)
            FS_IDLE: begin
                if (cpu_valid_i && !pend_hit) begin
                    if (hit_ok) begin
                        cpu_done_o = 1'b1;
                        if (cpu_we_i) begin
                            wr_en_o   = 1'b1;
                            wr_st_o   = LS_EXC;
                            wr_data_o = cpu_wdata_i;
                        end
                    end else begin
                        cpu_miss_o = 1'b1;
                        st_d = (line_st_i == LS_EXC && line_tag_i != cpu_tag_i) ? FS_WB : FS_MISS;
                    end
                end
            end
            FS_WB: begin
                bus_req_o = 1'b1;
                if (pend_hit) begin
                    st_d = FS_IDLE;
                end else if (bus_gnt_i) begin
                    bus_valid_o = 1'b1;
                    bus_cmd_o   = BC_WB;
                    bus_addr_o  = {line_tag_i, cpu_idx_i};
                    bus_wdata_o = line_data_i;
                    wr_en_o     = 1'b1;
                    wr_st_o     = LS_INV;
                    st_d        = FS_MISS;
                end
            end
            FS_MISS: begin
                bus_req_o = 1'b1;
                if (pend_hit) begin
                    st_d = FS_IDLE;
                end else if (bus_gnt_i) begin
                    bus_valid_o = 1'b1;
                    bus_cmd_o   = cpu_we_i ? BC_RDX : BC_RD;
                    bus_addr_o  = {cpu_tag_i, cpu_idx_i};
                    wr_en_o     = 1'b1;
                    wr_st_o     = cpu_we_i ? LS_EXC : LS_SHR;
                    wr_tag_o    = cpu_tag_i;
                    wr_data_o   = cpu_we_i ? cpu_wdata_i : bus_rdata_i;
                    st_d        = FS_RESP;
                end
            end
            FS_RESP: begin
                cpu_done_o = 1'b1;
                st_d       = FS_IDLE;
            end
            default: st_d = FS_IDLE;
        endcase
        cpu_rdata_o = cpu_done_o ? line_data_i : '0;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FS_IDLE;
        else        st_q <= st_d;
    end

    AST_WRITE_HIT_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FS_IDLE && cpu_done_o && cpu_we_i) |-> line_st_i == LS_EXC); // R2

    AST_RD_FILL_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_o && bus_cmd_o == BC_RD) |=> line_st_i == LS_SHR); // R3

    AST_RDX_FILL_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_o && bus_cmd_o == BC_RDX) |=> line_st_i == LS_EXC); // R3

    AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FS_IDLE && cpu_done_o) |-> !bus_valid_o); // R4

    AST_VICTIM_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_o && bus_cmd_o == BC_WB) |=> line_st_i == LS_INV); // R8

    AST_WAIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && !bus_gnt_i && !pend_hit) |=> $stable(line_st_i)); // R9

    AST_RESTART_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && pend_hit) |=> !bus_req_o); // R9

endmodule

// File: rtl/snoop_coh_ctrl.sv
// Module: top of the per-cache snooping coherence controller. Splits the
// addresses into tag and index, connects the line store to the request
// sequencer and the snoop responder, and exposes processor and bus ports.
// Assumes an external arbiter and an atomic bus where each granted
// transaction takes one cycle.
module snoop_coh_ctrl
    import coh_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int LINES  = 16,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid_i,
    input  logic              cpu_we_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic              cpu_done_o,
    output logic              cpu_miss_o,
    output logic              cpu_stall_o,
    output logic [DATA_W-1:0] cpu_rdata_o,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    output logic              bus_valid_o,
    output logic [1:0]        bus_cmd_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic [DATA_W-1:0] bus_rdata_i,
    input  logic              snp_valid_i,
    input  logic [1:0]        snp_cmd_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    output logic              snp_intervene_o,
    output logic [DATA_W-1:0] snp_data_o
);

    logic [IDX_W-1:0]  cpu_idx, snp_idx, wr_idx;
    logic [TAG_W-1:0]  cpu_tag, snp_tag;
    line_st_e          la_st, lb_st, wr_st, sw_st;
    logic [TAG_W-1:0]  la_tag, lb_tag, wr_tag;
    logic [DATA_W-1:0] la_data, lb_data, wr_data;
    logic              wr_en, sw_en;
    bus_cmd_e          own_cmd;

    // Address split: low bits index the line, high bits form the tag.
    always_comb begin
        cpu_idx     = cpu_addr_i[IDX_W-1:0];
        cpu_tag     = cpu_addr_i[ADDR_W-1:IDX_W];
        snp_idx     = snp_addr_i[IDX_W-1:0];
        snp_tag     = snp_addr_i[ADDR_W-1:IDX_W];
        wr_idx      = cpu_idx;
        bus_cmd_o   = own_cmd;
        cpu_stall_o = cpu_valid_i && !cpu_done_o;
    end

    coh_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rda_idx_i  (cpu_idx),
        .rda_st_o   (la_st),
        .rda_tag_o  (la_tag),
        .rda_data_o (la_data),
        .rdb_idx_i  (snp_idx),
        .rdb_st_o   (lb_st),
        .rdb_tag_o  (lb_tag),
        .rdb_data_o (lb_data),
        .wr_en_i    (wr_en),
        .wr_idx_i   (wr_idx),
        .wr_st_i    (wr_st),
        .wr_tag_i   (wr_tag),
        .wr_data_i  (wr_data),
        .sw_en_i    (sw_en),
        .sw_idx_i   (snp_idx),
        .sw_st_i    (sw_st)
    );

    coh_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .snp_valid_i (snp_valid_i),
        .snp_cmd_i   (bus_cmd_e'(snp_cmd_i)),
        .snp_tag_i   (snp_tag),
        .line_st_i   (lb_st),
        .line_tag_i  (lb_tag),
        .line_data_i (lb_data),
        .upd_en_o    (sw_en),
        .upd_st_o    (sw_st),
        .intervene_o (snp_intervene_o),
        .data_o      (snp_data_o)
    );

    coh_req_fsm #(.TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_valid_i (cpu_valid_i),
        .cpu_we_i    (cpu_we_i),
        .cpu_tag_i   (cpu_tag),
        .cpu_idx_i   (cpu_idx),
        .cpu_wdata_i (cpu_wdata_i),
        .cpu_done_o  (cpu_done_o),
        .cpu_miss_o  (cpu_miss_o),
        .cpu_rdata_o (cpu_rdata_o),
        .line_st_i   (la_st),
        .line_tag_i  (la_tag),
        .line_data_i (la_data),
        .snp_chg_i   (sw_en),
        .snp_idx_i   (snp_idx),
        .bus_req_o   (bus_req_o),
        .bus_gnt_i   (bus_gnt_i),
        .bus_valid_o (bus_valid_o),
        .bus_cmd_o   (own_cmd),
        .bus_addr_o  (bus_addr_o),
        .bus_wdata_o (bus_wdata_o),
        .bus_rdata_i (bus_rdata_i),
        .wr_en_o     (wr_en),
        .wr_st_o     (wr_st),
        .wr_tag_o    (wr_tag),
        .wr_data_o   (wr_data)
    );

    AST_QUIET_SNOOP_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_intervene_o |-> snp_data_o == '0); // R7

    AST_INTERVENE_ON_MISS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        snp_intervene_o |-> (snp_valid_i && snp_cmd_i != 2'd3)); // R5

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(!rst_n) |-> (!bus_req_o && !cpu_done_o)); // R1

endmodule

// File: tb/snoop_coh_ctrl_tb.sv
`timescale 1ns/1ps
module snoop_coh_ctrl_tb;

    localparam int AW = 10;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          a_valid = 0, a_we = 0, b_valid = 0, b_we = 0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic          a_done, a_miss, a_stall, a_req, a_bv, a_iv;
    logic          b_done, b_miss, b_stall, b_req, b_bv, b_iv;
    logic [DW-1:0] a_rdata, a_bwd, a_sd, b_rdata, b_bwd, b_sd, a_fill, b_fill;
    logic [1:0]    a_cmd, b_cmd;
    logic [AW-1:0] a_baddr, b_baddr;
    logic          a_gnt, b_gnt;
    logic          block_a = 1'b0;
    logic [DW-1:0] mem [1024];

    assign a_gnt  = a_req && !block_a;
    assign b_gnt  = b_req && !a_gnt;
    assign a_fill = b_iv ? b_sd : mem[a_baddr];
    assign b_fill = a_iv ? a_sd : mem[b_baddr];

    snoop_coh_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(16)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid_i(a_valid), .cpu_we_i(a_we), .cpu_addr_i(a_addr), .cpu_wdata_i(a_wdata),
        .cpu_done_o(a_done), .cpu_miss_o(a_miss), .cpu_stall_o(a_stall), .cpu_rdata_o(a_rdata),
        .bus_req_o(a_req), .bus_gnt_i(a_gnt), .bus_valid_o(a_bv), .bus_cmd_o(a_cmd),
        .bus_addr_o(a_baddr), .bus_wdata_o(a_bwd), .bus_rdata_i(a_fill),
        .snp_valid_i(b_bv), .snp_cmd_i(b_cmd), .snp_addr_i(b_baddr),
        .snp_intervene_o(a_iv), .snp_data_o(a_sd)
    );

    snoop_coh_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(16)) u_peer (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid_i(b_valid), .cpu_we_i(b_we), .cpu_addr_i(b_addr), .cpu_wdata_i(b_wdata),
        .cpu_done_o(b_done), .cpu_miss_o(b_miss), .cpu_stall_o(b_stall), .cpu_rdata_o(b_rdata),
        .bus_req_o(b_req), .bus_gnt_i(b_gnt), .bus_valid_o(b_bv), .bus_cmd_o(b_cmd),
        .bus_addr_o(b_baddr), .bus_wdata_o(b_bwd), .bus_rdata_i(b_fill),
        .snp_valid_i(a_bv), .snp_cmd_i(a_cmd), .snp_addr_i(a_baddr),
        .snp_intervene_o(b_iv), .snp_data_o(b_sd)
    );

    // Memory model: takes write-backs and intervened (dirty) data.
    initial for (int i = 0; i < 1024; i++) mem[i] = 32'hC0DE_0000 | i;
    always @(posedge clk) begin
        if (a_bv && a_cmd == 2'd3) mem[a_baddr] <= a_bwd;
        if (b_bv && b_cmd == 2'd3) mem[b_baddr] <= b_bwd;
        if (a_bv && b_iv) mem[a_baddr] <= b_sd;
        if (b_bv && a_iv) mem[b_baddr] <= a_sd;
    end

    // Bus monitor counters.
    int n_a_rd, n_a_rdx, n_a_wb, n_a_iv, n_b_iv, n_a_miss, n_quiet_bad;
    int first_a_cmd;
    always @(posedge clk) begin
        if (rst_n) begin
            if (a_bv) begin
                if (first_a_cmd < 0) first_a_cmd = int'(a_cmd);
                if (a_cmd == 2'd1) n_a_rd++;
                if (a_cmd == 2'd2) n_a_rdx++;
                if (a_cmd == 2'd3) n_a_wb++;
            end
            if (a_iv) n_a_iv++;
            if (b_iv) n_b_iv++;
            if (a_miss) n_a_miss++;
            if ((!a_iv && a_sd != '0) || (!b_iv && b_sd != '0)) n_quiet_bad++;
        end
    end

    int n_tests = 0, n_fail = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic clr();
        n_a_rd = 0; n_a_rdx = 0; n_a_wb = 0; n_a_iv = 0; n_b_iv = 0; n_a_miss = 0;
        first_a_cmd = -1;
    endtask

    // One processor access on controller A (sel=0) or B (sel=1).
    task automatic access(input bit sel, input bit we, input logic [AW-1:0] addr,
                          input logic [DW-1:0] wd, output logic [DW-1:0] rd, output int cyc);
        @(negedge clk);
        if (!sel) begin a_valid = 1; a_we = we; a_addr = addr; a_wdata = wd; end
        else      begin b_valid = 1; b_we = we; b_addr = addr; b_wdata = wd; end
        cyc = 0;
        rd  = '0;
        forever begin
            #1;
            cyc++;
            if (!sel && a_done) begin rd = a_rdata; break; end
            if (sel && b_done)  begin rd = b_rdata; break; end
            if (cyc > 500) break;
            @(negedge clk);
        end
        @(negedge clk);
        if (!sel) a_valid = 0; else b_valid = 0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] rd; int cyc;
        @(negedge clk); #1;
        chk("R1", "req after reset", 32'(a_req), 0);
        chk("R1", "done after reset", 32'(a_done), 0);
        chk("R1", "stall after reset", 32'(a_stall), 0);
        clr();
        access(0, 0, 10'h003, '0, rd, cyc);
        chk("R1", "first read is slow", 32'(cyc > 1), 1);
        chk("R1", "first read on bus", 32'(n_a_rd), 1);
        chk("R3", "read fill data", rd, 32'hC0DE_0003);
    endtask

    task automatic t_read_hit();
        logic [DW-1:0] rd; int cyc;
        clr();
        access(0, 0, 10'h003, '0, rd, cyc);
        chk("R4", "read hit latency", 32'(cyc), 1);
        chk("R4", "read hit no bus", 32'(n_a_rd + n_a_rdx + n_a_wb), 0);
        chk("R4", "read hit data", rd, 32'hC0DE_0003);
    endtask

    task automatic t_write_miss();
        logic [DW-1:0] rd; int cyc;
        clr();
        access(0, 1, 10'h00A, 32'h1234_5678, rd, cyc);
        chk("R3", "write miss cmd 2", 32'(n_a_rdx), 1);
        access(0, 0, 10'h00A, '0, rd, cyc);
        chk("R4", "read after write miss is hit", 32'(cyc), 1);
        chk("R3", "write miss filled cpu data", rd, 32'h1234_5678);
    endtask

    task automatic t_upgrade_and_ownership();
        logic [DW-1:0] rd; int cyc;
        access(0, 0, 10'h005, '0, rd, cyc);
        access(1, 0, 10'h005, '0, rd, cyc);
        clr();
        access(0, 1, 10'h005, 32'hAAAA_0001, rd, cyc);
        chk("R2", "shared write goes to bus", 32'(n_a_rdx), 1);
        chk("R2", "shared write not one cycle", 32'(cyc > 1), 1);
        chk("R2", "shared peer does not intervene", 32'(n_b_iv), 0);
        clr();
        access(1, 0, 10'h005, '0, rd, cyc);
        chk("R5", "peer copy was invalidated", 32'(cyc > 1), 1);
        chk("R6", "owner supplies read data", rd, 32'hAAAA_0001);
        chk("R6", "owner intervened once", 32'(n_a_iv), 1);
        chk("R6", "memory updated by intervention", mem[5], 32'hAAAA_0001);
        clr();
        access(0, 1, 10'h005, 32'hAAAA_0002, rd, cyc);
        chk("R6", "downgraded line needs bus to write", 32'(n_a_rdx), 1);
        clr();
        access(0, 1, 10'h005, 32'hAAAA_0003, rd, cyc);
        chk("R4", "write hit exclusive latency", 32'(cyc), 1);
        chk("R4", "write hit exclusive no bus", 32'(n_a_rd + n_a_rdx + n_a_wb), 0);
    endtask

    task automatic t_snoop_write_miss();
        logic [DW-1:0] rd; int cyc;
        clr();
        access(1, 1, 10'h005, 32'hBBBB_0001, rd, cyc);
        chk("R5", "dirty owner intervenes on write miss", 32'(n_a_iv), 1);
        chk("R5", "dirty data written back", mem[5], 32'hAAAA_0003);
        clr();
        access(0, 0, 10'h005, '0, rd, cyc);
        chk("R5", "invalidated line misses", 32'(n_a_rd), 1);
        chk("R5", "read gets new owner data", rd, 32'hBBBB_0001);
    endtask

    task automatic t_evict();
        logic [DW-1:0] rd; int cyc;
        access(0, 1, 10'h006, 32'h6666_0006, rd, cyc);
        clr();
        access(0, 0, 10'h016, '0, rd, cyc);
        chk("R8", "victim written back", 32'(n_a_wb), 1);
        chk("R8", "write-back comes first", 32'(first_a_cmd), 3);
        chk("R8", "read miss follows", 32'(n_a_rd), 1);
        chk("R8", "memory holds victim data", mem[6], 32'h6666_0006);
        chk("R3", "conflicting read data", rd, 32'hC0DE_0016);
    endtask

    task automatic t_restart();
        logic [DW-1:0] rda, rdb; int ca, cb;
        access(0, 1, 10'h008, 32'h8888_0008, rda, ca);
        clr();
        block_a = 1'b1;
        fork
            access(0, 0, 10'h018, '0, rda, ca);
            begin
                repeat (4) @(negedge clk);
                #1;
                chk("R9", "request stalls while blocked", 32'(a_stall), 1);
                access(1, 0, 10'h008, '0, rdb, cb);
                repeat (2) @(negedge clk);
                block_a = 1'b0;
            end
        join
        chk("R6", "peer reads dirty block", rdb, 32'h8888_0008);
        chk("R9", "no write-back after restart", 32'(n_a_wb), 0);
        chk("R9", "single read after restart", 32'(n_a_rd), 1);
        chk("R9", "request re-evaluated", 32'(n_a_miss >= 2), 1);
        chk("R9", "restarted read data", rda, 32'hC0DE_0018);
        chk("R6", "memory got intervened block", mem[8], 32'h8888_0008);
    endtask

    initial begin
        clr();
        n_quiet_bad = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_hit();
        t_write_miss();
        t_upgrade_and_ownership();
        t_snoop_write_miss();
        t_evict();
        t_restart();
        chk("R7", "snoop data quiet without intervene", 32'(n_quiet_bad), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule